// File: doc/BRIEF.md
# Pixel Hit Timestamp Recorder

This block sits in every pixel of a tracking sensor and records when particle hits arrive during an acquisition window (a bunch train). A global timestamp counter is broadcast to all pixels on a shared bus. Whenever the pixel's comparator output, already brought into the system clock domain, goes from low to high while the train is active, the pixel copies the current bus value into the next free slot of a small hit log. A write pointer then moves to the following slot.

Between trains the array readout logic visits each pixel. The pixel shows how many hits it holds, the stored timestamps in arrival order, and a sticky overflow flag for hits that found the log full. A pixel with nothing recorded raises an empty flag, so the readout can skip it at once. A read-done strobe from the readout logic clears the log for the next train. A memory-enable output is high only while the log holds data that has not been read yet, so storage that is not in use can be powered down.

Top module: `hit_stamp_pixel`

## Requirements
- R1: After reset, with the train flag low, the pixel shows empty high, a hit count of 0, all entry fields zero, overflow low and memory enable low.
- R2: A low-to-high transition of the fire input, seen in a cycle where the train flag is high, stores the timestamp bus value of that same cycle. The first hit goes to entry 0 (bits [13:0] of the entry vector) and the second to entry 1 (bits [27:14]).
- R3: Only rising edges count. If the fire input stays high for several cycles, exactly one hit is recorded. A further hit needs the input to go low and then high again.
- R4: A rising edge that arrives while both entries are full is dropped and leaves both entries unchanged. It sets a sticky overflow flag, which is shown between trains.
- R5: Between trains, empty is high exactly when the hit count is 0. An entry field at or above the hit count reads as zero, because zero is the reserved "no hit" timestamp.
- R6: While the train flag is high, the readout port shows empty low, count 0, all entries zero and overflow low. A read-done strobe given during a train has no effect.
- R7: Rising edges of the fire input while the train flag is low are not recorded.
- R8: A read-done strobe between trains clears the hit count, the pointer and the overflow flag. The next recorded hit then goes to entry 0.
- R9: Memory enable goes high with the first recorded hit and stays high until a read-done strobe clears the log.
- R10: Rising edges two clock cycles apart (fire high, low, high) are both recorded. All readout outputs are registered and show new state one clock after it is written.
- R11: Entries that have not been read stay in place across a train boundary. Hits in a later train go into the remaining free slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ts_bus_i | input | 14 | Global timestamp broadcast, nonzero during a train |
| fire_i | input | 1 | Comparator fire level, already synchronised to clk |
| train_i | input | 1 | High while a bunch train is in progress |
| rd_done_i | input | 1 | One-cycle strobe: this pixel has been read out |
| empty_o | output | 1 | High between trains when no hit is held |
| hit_cnt_o | output | 2 | Number of stored hits, 0 to 2 |
| entries_o | output | 28 | Stored timestamps; entry k at bits [14k+13:14k] |
| ovf_o | output | 1 | Sticky flag: a hit was dropped because the log was full |
| mem_en_o | output | 1 | Enable for the hit log storage |

## Verification
The assertions take three things for granted about the inputs. The fire level is already synchronous to the clock. The timestamp bus never carries zero while a write can happen. Reset is held for at least one clock at start-up. The stimulus drives every input at the falling clock edge. Each train numbers its cycles from 1 upward, so a write never sees the reserved zero value. Read-done pulses and fire toggles are placed both inside and outside trains, which exercises the ignore paths without breaking these assumptions.

// File: rtl/pix_stamp_pkg.sv
package pix_stamp_pkg;
  localparam int TS_W_DEF  = 14;
  localparam int DEPTH_DEF = 2;

  function automatic int cnt_bits(input int depth);
    return $clog2(depth + 1);
  endfunction

  function automatic int idx_bits(input int depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction
endpackage

// File: rtl/pix_fire_edge.sv
module pix_fire_edge (
  input  logic clk,
  input  logic rst,
  input  logic fire_i,
  output logic rise_o
);
  logic fire_q;

  always_ff @(posedge clk) begin
    if (rst) fire_q <= 1'b0;
    else     fire_q <= fire_i;
  end

  assign rise_o = fire_i & ~fire_q;

  // R3: a level held high cannot produce two edges in a row
  a_r3_single_rise: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o);
endmodule

// File: rtl/pix_write_ctrl.sv
module pix_write_ctrl
  import pix_stamp_pkg::*;
#(
  parameter int DEPTH = DEPTH_DEF,
  localparam int CNT_W = cnt_bits(DEPTH),
  localparam int IDX_W = idx_bits(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             train_i,
  input  logic             rise_i,
  input  logic             rd_done_i,
  output logic             wr_en_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o,
  output logic             mem_en_o
);
  logic [CNT_W-1:0] ptr_q;
  logic             ovf_q;
  logic             men_q;
  logic             full;
  logic             clear;
  logic             drop;

  assign full     = (ptr_q == CNT_W'(DEPTH));
  assign wr_en_o  = train_i & rise_i & ~full;
  assign drop     = train_i & rise_i & full;
  assign clear    = rd_done_i & ~train_i;
  assign wr_idx_o = IDX_W'(ptr_q);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      ptr_q <= '0;
      ovf_q <= 1'b0;
      men_q <= 1'b0;
    end else begin
      if (wr_en_o) begin
        ptr_q <= ptr_q + CNT_W'(1);
        men_q <= 1'b1;
      end
      if (drop) ovf_q <= 1'b1;
    end
  end

  assign cnt_o    = ptr_q;
  assign ovf_o    = ovf_q;
  assign mem_en_o = men_q;

  // R4: pointer never passes the log depth
  a_r4_ptr_bound: assert property (@(posedge clk) disable iff (rst)
    ptr_q <= CNT_W'(DEPTH));
  // R4: overflow only once the log is full
  a_r4_ovf_full: assert property (@(posedge clk) disable iff (rst)
    ovf_q |-> full);
  // R9: storage enabled exactly while data is held
  a_r9_mem_en: assert property (@(posedge clk) disable iff (rst)
    men_q == (ptr_q != '0));
  // R8: read-done between trains empties the log
  a_r8_clear: assert property (@(posedge clk) disable iff (rst)
    (rd_done_i && !train_i) |=> (ptr_q == '0 && !ovf_q));
  // R11: outside a train and without read-done the pointer holds
  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    (!train_i && !rd_done_i) |=> $stable(ptr_q));
endmodule

// File: rtl/pix_hit_mem.sv
module pix_hit_mem
  import pix_stamp_pkg::*;
#(
  parameter int TS_W  = TS_W_DEF,
  parameter int DEPTH = DEPTH_DEF,
  localparam int IDX_W = idx_bits(DEPTH)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  we_i,
  input  logic [IDX_W-1:0]      waddr_i,
  input  logic [TS_W-1:0]       wdata_i,
  output logic [DEPTH*TS_W-1:0] cells_o
);
  logic [TS_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    assign cells_o[g*TS_W +: TS_W] = mem_q[g];
  end

  // R2: the reserved zero timestamp is never written
  a_r2_ts_nonzero: assert property (@(posedge clk) disable iff (rst)
    we_i |-> (wdata_i != '0));
endmodule

// File: rtl/pix_readout.sv
module pix_readout
  import pix_stamp_pkg::*;
#(
  parameter int TS_W  = TS_W_DEF,
  parameter int DEPTH = DEPTH_DEF,
  localparam int CNT_W = cnt_bits(DEPTH)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  train_i,
  input  logic [CNT_W-1:0]      cnt_i,
  input  logic                  ovf_i,
  input  logic [DEPTH*TS_W-1:0] cells_i,
  output logic                  empty_o,
  output logic [CNT_W-1:0]      cnt_o,
  output logic [DEPTH*TS_W-1:0] entries_o,
  output logic                  ovf_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      empty_o <= 1'b1;
      cnt_o   <= '0;
      ovf_o   <= 1'b0;
    end else begin
      empty_o <= ~train_i & (cnt_i == '0);
      cnt_o   <= train_i ? '0 : cnt_i;
      ovf_o   <= ~train_i & ovf_i;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst) entries_o[g*TS_W +: TS_W] <= '0;
      else if (!train_i && (CNT_W'(g) < cnt_i))
        entries_o[g*TS_W +: TS_W] <= cells_i[g*TS_W +: TS_W];
      else
        entries_o[g*TS_W +: TS_W] <= '0;
    end
  end

  // R6: port is quiet during a train
  a_r6_quiet: assert property (@(posedge clk) disable iff (rst)
    $past(train_i) |-> (!empty_o && cnt_o == '0 && !ovf_o && entries_o == '0));
  // R5: an empty pixel shows no timestamps
  a_r5_empty_zero: assert property (@(posedge clk) disable iff (rst)
    empty_o |-> (entries_o == '0 && cnt_o == '0));
endmodule

// File: rtl/hit_stamp_pixel.sv
module hit_stamp_pixel
  import pix_stamp_pkg::*;
#(
  parameter int TS_W  = TS_W_DEF,
  parameter int DEPTH = DEPTH_DEF,
  localparam int CNT_W = cnt_bits(DEPTH),
  localparam int IDX_W = idx_bits(DEPTH)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [TS_W-1:0]       ts_bus_i,
  input  logic                  fire_i,
  input  logic                  train_i,
  input  logic                  rd_done_i,
  output logic                  empty_o,
  output logic [CNT_W-1:0]      hit_cnt_o,
  output logic [DEPTH*TS_W-1:0] entries_o,
  output logic                  ovf_o,
  output logic                  mem_en_o
);
  logic                  rise;
  logic                  wr_en;
  logic [IDX_W-1:0]      wr_idx;
  logic [CNT_W-1:0]      cnt;
  logic                  ovf;
  logic [DEPTH*TS_W-1:0] cells;

  pix_fire_edge i_edge (
    .clk(clk), .rst(rst), .fire_i(fire_i), .rise_o(rise)
  );

  pix_write_ctrl #(.DEPTH(DEPTH)) i_ctrl (
    .clk(clk), .rst(rst), .train_i(train_i), .rise_i(rise),
    .rd_done_i(rd_done_i), .wr_en_o(wr_en), .wr_idx_o(wr_idx),
    .cnt_o(cnt), .ovf_o(ovf), .mem_en_o(mem_en_o)
  );

  pix_hit_mem #(.TS_W(TS_W), .DEPTH(DEPTH)) i_mem (
    .clk(clk), .rst(rst), .we_i(wr_en), .waddr_i(wr_idx),
    .wdata_i(ts_bus_i), .cells_o(cells)
  );

  pix_readout #(.TS_W(TS_W), .DEPTH(DEPTH)) i_rd (
    .clk(clk), .rst(rst), .train_i(train_i), .cnt_i(cnt), .ovf_i(ovf),
    .cells_i(cells), .empty_o(empty_o), .cnt_o(hit_cnt_o),
    .entries_o(entries_o), .ovf_o(ovf_o)
  );
endmodule

// File: tb/test_hit_stamp_pixel.sv
module test_hit_stamp_pixel;
  localparam int CLK_P = 10;
  localparam int TS_W  = 14;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [TS_W-1:0] ts_bus = '0;
  logic            fire = 1'b0;
  logic            train = 1'b0;
  logic            rd_done = 1'b0;
  logic            empty;
  logic [1:0]      hit_cnt;
  logic [2*TS_W-1:0] entries;
  logic            ovf;
  logic            mem_en;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  int              m_cnt = 0;
  logic [TS_W-1:0] m_e [2];
  bit              m_ovf = 0;
  bit              m_prev = 0;
  logic [TS_W-1:0] tsc = 14'd1;

  always #(CLK_P/2) clk = ~clk;

  hit_stamp_pixel i_hit_stamp_pixel (
    .clk(clk), .rst(rst), .ts_bus_i(ts_bus), .fire_i(fire),
    .train_i(train), .rd_done_i(rd_done), .empty_o(empty),
    .hit_cnt_o(hit_cnt), .entries_o(entries), .ovf_o(ovf),
    .mem_en_o(mem_en)
  );

  function automatic logic [2*TS_W-1:0] exp_entries();
    logic [2*TS_W-1:0] v = '0;
    if (m_cnt > 0) v[TS_W-1:0] = m_e[0];
    if (m_cnt > 1) v[2*TS_W-1:TS_W] = m_e[1];
    return v;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic tr, input logic f, input logic rd);
    bit rise;
    @(negedge clk);
    train = tr; fire = f; rd_done = rd;
    if (tr) begin ts_bus = tsc; tsc = tsc + 1'b1; end
    else ts_bus = 14'($urandom_range(1, 16383));
    @(posedge clk);
    rise = f && !m_prev;
    if (tr && rise) begin
      if (m_cnt < 2) begin m_e[m_cnt] = ts_bus; m_cnt++; end
      else m_ovf = 1;
    end
    if (!tr && rd) begin m_cnt = 0; m_ovf = 0; end
    m_prev = f;
  endtask

  task automatic start_train();
    tsc = 14'd1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0);
  endtask

  task automatic check_idle(input string req);
    @(negedge clk);
    chk(req, "empty", 32'(empty), 32'(m_cnt == 0));
    chk(req, "count", 32'(hit_cnt), 32'(m_cnt));
    chk(req, "entries", 32'(entries), 32'(exp_entries()));
    chk(req, "ovf", 32'(ovf), 32'(m_ovf));
    chk(req, "mem_en", 32'(mem_en), 32'(m_cnt != 0));
  endtask

  task automatic check_busy(input string req);
    @(negedge clk);
    chk(req, "empty", 32'(empty), 32'd0);
    chk(req, "count", 32'(hit_cnt), 32'd0);
    chk(req, "entries", 32'(entries), 32'd0);
    chk(req, "ovf", 32'(ovf), 32'd0);
    chk(req, "mem_en", 32'(mem_en), 32'(m_cnt != 0));
  endtask

  task automatic read_out(input string req);
    step(1'b0, 1'b0, 1'b1);
    idle(2);
    check_idle(req);
  endtask

  initial begin
    #(CLK_P * 190000);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    check_idle("R1");

    // R2 / R10: two hits two cycles apart, order kept
    start_train();
    step(1, 0, 0); step(1, 1, 0); step(1, 0, 0); step(1, 1, 0); step(1, 0, 0);
    check_busy("R6");
    idle(2);
    check_idle("R2");
    chk("R10", "entry1", 32'(entries[2*TS_W-1:TS_W]), 32'd4);
    read_out("R8");

    // R3: held high counts once
    start_train();
    step(1, 0, 0);
    for (int i = 0; i < 6; i++) step(1, 1, 0);
    step(1, 0, 0);
    idle(2);
    check_idle("R3");
    chk("R9", "mem_en", 32'(mem_en), 32'd1);
    read_out("R9");

    // R4: third and fourth hits dropped
    start_train();
    for (int i = 0; i < 4; i++) begin step(1, 1, 0); step(1, 0, 0); end
    idle(2);
    check_idle("R4");
    chk("R4", "entry0", 32'(entries[TS_W-1:0]), 32'd1);
    read_out("R8");

    // R7: fire toggles outside a train
    for (int i = 0; i < 5; i++) begin step(0, 1, 0); step(0, 0, 0); end
    check_idle("R7");

    // R6: read-done inside a train ignored
    start_train();
    step(1, 1, 0); step(1, 0, 1); step(1, 0, 1);
    check_busy("R6");
    idle(2);
    check_idle("R6");

    // R11: unread entry survives into next train
    start_train();
    step(1, 0, 0); step(1, 0, 0); step(1, 1, 0); step(1, 0, 0);
    idle(2);
    check_idle("R11");
    read_out("R5");

    // Random trains
    for (int t = 0; t < 40; t++) begin
      int len = $urandom_range(4, 30);
      start_train();
      for (int c = 0; c < len; c++) begin
        step(1, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 7) == 0));
        if (c == len / 2) check_busy("R6");
      end
      for (int c = 0; c < 3; c++) step(0, 1'($urandom_range(0, 1)), 1'b0);
      idle(2);
      check_idle("R5");
      if ($urandom_range(0, 9) < 7) read_out("R8");
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule